// File: doc/BRIEF.md
# Instruction Prefix Modifier Decoder

This block sits beside the main instruction decoder of a small 8-bit processor core. It watches every opcode byte the core fetches. Four of those byte values are treated as one-shot prefixes rather than as instructions. One prefix turns direct memory operands into pointer (indirect) operands. One swaps the roles of the accumulator and X. One swaps the roles of the accumulator and Y. One lets the stack pointer take over the data role of Y.

A prefix collects in a small state register. It acts on the next ordinary instruction, and it is dropped when that instruction signals completion. While the core runs the modified instruction, the block rewrites the addressing-mode code supplied by the main decoder. It also drives four register-role selects that the register file uses in place of its normal A, X and Y choices.

Prefix bytes execute as single-cycle no-ops. An interrupt request is held off from the first prefix until the modified instruction has been fetched, so the prefix and its target are never split.

Top module: `pfxdec_top`

## Requirements
- R1: With the indirection prefix active, base mode ZP (2) yields ZPI (8) and ABS (5) yields ABSI (11). Mode codes: IMP 0, IMM 1, ZP 2, ZPX 3, ZPY 4, ABS 5, ABSX 6, ABSY 7, ZPI 8, ZPXI 9, ZPIY 10, ABSI 11, ABSXI 12, ABSIY 13, REL 14, ACC 15.
- R2: With the indirection prefix active, the indexed modes are converted: ZPX (3) to ZPXI (9), ZPY (4) to ZPIY (10), ABSX (6) to ABSXI (12), and ABSY (7) to ABSIY (13).
- R3: The indirection prefix leaves the mode unchanged in two cases: when the opcode's two low bits are 01 (an instruction that already has both direct and pointer zero-page forms), and for every mode outside 2..7.
- R4: The A/X swap and A/Y swap prefixes never coexist; a later conflicting swap is ignored and the earlier one kept. Register select codes: A 0, X 1, Y 2, S 3. Under A/X swap, acc_sel is X and xreg_sel is A. Under A/Y swap, acc_sel is Y and both yreg_sel and yidx_sel are A.
- R5: The S-for-Y prefix is ignored after an A/Y swap, and an A/Y swap is ignored after S-for-Y. It may combine with A/X swap. Under S-for-Y, yreg_sel is S while yidx_sel stays Y.
- R6: Prefix state clears at the clock edge where insn_done is high after the modified instruction was fetched. An insn_done pulse between prefixes and their target has no effect.
- R7: A fetch of opcode 0x0B (indirection), 0x1B (A/X swap), 0x2B (A/Y swap) or 0x3B (S-for-Y) raises pfx_nop in that cycle.
- R8: irq_inhibit is high, and irq_grant low, during a prefix fetch and in every cycle from the first prefix until the modified instruction is fetched.
- R9: Reset clears all prefix state.
- R10: With no prefix pending, mode_out equals base_mode and the selects are A, X, Y, Y.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_en | input | 1 | An opcode byte is being fetched this cycle |
| opcode | input | 8 | Fetched opcode byte |
| base_mode | input | 4 | Addressing-mode code from the main decoder |
| insn_done | input | 1 | The current instruction completes this cycle |
| irq_req | input | 1 | Raw interrupt request |
| mode_out | output | 4 | Addressing-mode code after prefix remapping |
| acc_sel | output | 2 | Register used in the accumulator role |
| xreg_sel | output | 2 | Register used in the X role |
| yreg_sel | output | 2 | Register used in the Y data role |
| yidx_sel | output | 2 | Register used for Y indexing |
| pfx_nop | output | 1 | Current fetch is a prefix; execute as a one-cycle no-op |
| irq_inhibit | output | 1 | Interrupts must not be taken now |
| irq_grant | output | 1 | Interrupt request after inhibit gating |

## Verification
A wrong prefix state register shows up at the selects and at mode_out in the first cycle after the faulty edge. The outputs are combinational from that state, so the error is visible without waiting for another fetch. A missed clear shows as a stale swap or a remapped mode on the next unprefixed instruction. A broken exclusion rule shows as A appearing in two roles at once, or as S used for Y-indexing. An error in the pending or armed tracking shows first at irq_grant: the request leaks through between a prefix and its target, or it stays blocked after the target has been fetched.

// File: rtl/pfxdec_pkg.sv
package pfxdec_pkg;

  typedef enum logic [3:0] {
    AM_IMP   = 4'd0,
    AM_IMM   = 4'd1,
    AM_ZP    = 4'd2,
    AM_ZPX   = 4'd3,
    AM_ZPY   = 4'd4,
    AM_ABS   = 4'd5,
    AM_ABSX  = 4'd6,
    AM_ABSY  = 4'd7,
    AM_ZPI   = 4'd8,
    AM_ZPXI  = 4'd9,
    AM_ZPIY  = 4'd10,
    AM_ABSI  = 4'd11,
    AM_ABSXI = 4'd12,
    AM_ABSIY = 4'd13,
    AM_REL   = 4'd14,
    AM_ACC   = 4'd15
  } amode_e;

  typedef enum logic [1:0] {
    RS_A = 2'd0,
    RS_X = 2'd1,
    RS_Y = 2'd2,
    RS_S = 2'd3
  } rsel_e;

  // Prefix state: bit per modifier
  typedef struct packed {
    logic ind;
    logic ax;
    logic ay;
    logic sy;
  } pfx_t;

  localparam int NPFX    = 4;
  localparam int HIT_IND = 0;
  localparam int HIT_AX  = 1;
  localparam int HIT_AY  = 2;
  localparam int HIT_SY  = 3;

  // Direct mode to its pointer counterpart; others pass through
  function automatic amode_e to_indirect(amode_e m);
    case (m)
      AM_ZP:   return AM_ZPI;
      AM_ZPX:  return AM_ZPXI;
      AM_ZPY:  return AM_ZPIY;
      AM_ABS:  return AM_ABSI;
      AM_ABSX: return AM_ABSXI;
      AM_ABSY: return AM_ABSIY;
      default: return m;
    endcase
  endfunction

  // Opcode group that already owns both direct and pointer zp forms
  function automatic logic has_dual_zp(logic [1:0] low_bits);
    return low_bits == 2'b01;
  endfunction

  // Apply one prefix hit to an accumulated state under exclusion rules
  function automatic pfx_t merge_prefix(pfx_t base, logic [NPFX-1:0] hit);
    pfx_t r;
    r = base;
    if (hit[HIT_IND]) r.ind = 1'b1;
    if (hit[HIT_AX] && !base.ay) r.ax = 1'b1;
    if (hit[HIT_AY] && !base.ax && !base.sy) r.ay = 1'b1;
    if (hit[HIT_SY] && !base.ay) r.sy = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/pfxdec_accum.sv
module pfxdec_accum
  import pfxdec_pkg::*;
#(
  parameter int              OPW      = 8,
  parameter logic [OPW-1:0]  CODE_IND = 8'h0B,
  parameter logic [OPW-1:0]  CODE_AX  = 8'h1B,
  parameter logic [OPW-1:0]  CODE_AY  = 8'h2B,
  parameter logic [OPW-1:0]  CODE_SY  = 8'h3B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_en,
  input  logic [OPW-1:0] opcode,
  input  logic           insn_done,
  output pfx_t           pfx_q,
  output logic           armed_q,
  output logic           pfx_fetch,
  output logic           pending
);

  logic [OPW-1:0]  codes [NPFX];
  logic [NPFX-1:0] hit;
  pfx_t            base_st;
  pfx_t            pfx_d;
  logic            armed_d;

  assign codes[HIT_IND] = CODE_IND;
  assign codes[HIT_AX]  = CODE_AX;
  assign codes[HIT_AY]  = CODE_AY;
  assign codes[HIT_SY]  = CODE_SY;

  for (genvar i = 0; i < NPFX; i++) begin : g_match
    assign hit[i] = fetch_en && (opcode == codes[i]);
  end

  assign pfx_fetch = |hit;
  assign pending   = (pfx_q != '0) && !armed_q;

  always_comb begin
    base_st = armed_q ? '0 : pfx_q;
    pfx_d   = pfx_q;
    armed_d = armed_q;
    if (insn_done && armed_q) begin
      pfx_d   = '0;
      armed_d = 1'b0;
    end else if (pfx_fetch) begin
      pfx_d   = merge_prefix(base_st, hit);
      armed_d = 1'b0;
    end else if (fetch_en) begin
      armed_d = armed_q || (pfx_q != '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pfx_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      pfx_q   <= pfx_d;
      armed_q <= armed_d;
    end
  end

  a_r4_swaps_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pfx_q.ax && pfx_q.ay));

  a_r5_sy_ay_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pfx_q.sy && pfx_q.ay));

  a_r6_clear_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && armed_q && !fetch_en) |=> (pfx_q == '0 && !armed_q));

  a_r6_done_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_done && !armed_q && !fetch_en) |=> $stable(pfx_q));

  a_r7_one_code_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));

endmodule

// File: rtl/pfxdec_remap.sv
module pfxdec_remap
  import pfxdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ind_on,
  input  logic [1:0] op_low,
  input  logic [3:0] base_mode,
  output logic [3:0] mode_out,
  output logic       ind_applied
);

  amode_e m_in;
  amode_e m_conv;

  assign m_in        = amode_e'(base_mode);
  assign m_conv      = to_indirect(m_in);
  assign ind_applied = ind_on && !has_dual_zp(op_low) && (m_conv != m_in);
  assign mode_out    = ind_applied ? m_conv : m_in;

  a_r3_dual_form_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (op_low == 2'b01) |-> (mode_out == base_mode));

  a_r1_only_when_ind: assert property (@(posedge clk) disable iff (!rst_n)
    !ind_on |-> (mode_out == base_mode));

  a_r2_result_is_pointer: assert property (@(posedge clk) disable iff (!rst_n)
    ind_applied |-> (mode_out >= 4'd8 && mode_out <= 4'd13));

endmodule

// File: rtl/pfxdec_regsel.sv
module pfxdec_regsel
  import pfxdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfx_t       pfx,
  output logic [1:0] acc_sel,
  output logic [1:0] xreg_sel,
  output logic [1:0] yreg_sel,
  output logic [1:0] yidx_sel
);

  rsel_e acc_r, xr_r, yr_r, yi_r;

  always_comb begin
    acc_r = RS_A;
    xr_r  = RS_X;
    yr_r  = RS_Y;
    yi_r  = RS_Y;
    if (pfx.ax) begin
      acc_r = RS_X;
      xr_r  = RS_A;
    end
    if (pfx.ay) begin
      acc_r = RS_Y;
      yr_r  = RS_A;
      yi_r  = RS_A;
    end
    if (pfx.sy) begin
      yr_r = RS_S;
    end
  end

  assign acc_sel  = acc_r;
  assign xreg_sel = xr_r;
  assign yreg_sel = yr_r;
  assign yidx_sel = yi_r;

  a_r5_s_never_index: assert property (@(posedge clk) disable iff (!rst_n)
    yidx_sel != 2'd3);

  a_r4_acc_single_role: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel != 2'd0) |-> ((xreg_sel == 2'd0) != (yreg_sel == 2'd0)));

endmodule

// File: rtl/pfxdec_top.sv
module pfxdec_top
  import pfxdec_pkg::*;
#(
  parameter int              OPW      = 8,
  parameter logic [OPW-1:0]  CODE_IND = 8'h0B,
  parameter logic [OPW-1:0]  CODE_AX  = 8'h1B,
  parameter logic [OPW-1:0]  CODE_AY  = 8'h2B,
  parameter logic [OPW-1:0]  CODE_SY  = 8'h3B
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fetch_en,
  input  logic [OPW-1:0] opcode,
  input  logic [3:0]     base_mode,
  input  logic           insn_done,
  input  logic           irq_req,
  output logic [3:0]     mode_out,
  output logic [1:0]     acc_sel,
  output logic [1:0]     xreg_sel,
  output logic [1:0]     yreg_sel,
  output logic [1:0]     yidx_sel,
  output logic           pfx_nop,
  output logic           irq_inhibit,
  output logic           irq_grant
);

  pfx_t pfx_q;
  logic armed_q;
  logic pfx_fetch;
  logic pending;
  logic ind_applied;

  pfxdec_accum #(
    .OPW(OPW), .CODE_IND(CODE_IND), .CODE_AX(CODE_AX),
    .CODE_AY(CODE_AY), .CODE_SY(CODE_SY)
  ) u_accum (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .opcode(opcode),
    .insn_done(insn_done), .pfx_q(pfx_q), .armed_q(armed_q),
    .pfx_fetch(pfx_fetch), .pending(pending)
  );

  pfxdec_remap u_remap (
    .clk(clk), .rst_n(rst_n), .ind_on(pfx_q.ind), .op_low(opcode[1:0]),
    .base_mode(base_mode), .mode_out(mode_out), .ind_applied(ind_applied)
  );

  pfxdec_regsel u_regsel (
    .clk(clk), .rst_n(rst_n), .pfx(pfx_q), .acc_sel(acc_sel),
    .xreg_sel(xreg_sel), .yreg_sel(yreg_sel), .yidx_sel(yidx_sel)
  );

  assign pfx_nop     = pfx_fetch;
  assign irq_inhibit = pending || pfx_fetch;
  assign irq_grant   = irq_req && !irq_inhibit;

  a_r8_irq_held_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !irq_grant);

  a_r7_prefix_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_nop |-> (irq_inhibit && !irq_grant));

  a_r1_ind_needs_state: assert property (@(posedge clk) disable iff (!rst_n)
    ind_applied |-> pfx_q.ind);

endmodule

// File: tb/pfxdec_top_test.sv
module pfxdec_top_test;

  localparam logic [7:0] C_IND = 8'h0B;
  localparam logic [7:0] C_AX  = 8'h1B;
  localparam logic [7:0] C_AY  = 8'h2B;
  localparam logic [7:0] C_SY  = 8'h3B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fetch_en = 1'b0;
  logic [7:0] opcode = 8'hEA;
  logic [3:0] base_mode = 4'd0;
  logic       insn_done = 1'b0;
  logic       irq_req = 1'b0;
  logic [3:0] mode_out;
  logic [1:0] acc_sel, xreg_sel, yreg_sel, yidx_sel;
  logic       pfx_nop, irq_inhibit, irq_grant;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // bench model of prefix state
  bit m_ind, m_ax, m_ay, m_sy;

  always #5 clk = ~clk;

  pfxdec_top uut (
    .clk(clk), .rst_n(rst_n), .fetch_en(fetch_en), .opcode(opcode),
    .base_mode(base_mode), .insn_done(insn_done), .irq_req(irq_req),
    .mode_out(mode_out), .acc_sel(acc_sel), .xreg_sel(xreg_sel),
    .yreg_sel(yreg_sel), .yidx_sel(yidx_sel), .pfx_nop(pfx_nop),
    .irq_inhibit(irq_inhibit), .irq_grant(irq_grant)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_mode(int m, bit ind, logic [7:0] op);
    if (!ind || op[1:0] == 2'b01) return m;
    if (m >= 2 && m <= 7) return m + 6;
    return m;
  endfunction

  task automatic check_selects(input string tag);
    int ea, ex, eyr, eyi;
    ea  = m_ax ? 1 : (m_ay ? 2 : 0);
    ex  = m_ax ? 0 : 1;
    eyr = m_ay ? 0 : (m_sy ? 3 : 2);
    eyi = m_ay ? 0 : 2;
    check(acc_sel == ea, {tag, " acc_sel"}, acc_sel, ea);
    check(xreg_sel == ex, {tag, " xreg_sel"}, xreg_sel, ex);
    check(yreg_sel == eyr, {tag, " yreg_sel"}, yreg_sel, eyr);
    check(yidx_sel == eyi, {tag, " yidx_sel"}, yidx_sel, eyi);
  endtask

  task automatic model_prefix(input int p);
    case (p)
      0: m_ind = 1'b1;
      1: if (!m_ay) m_ax = 1'b1;
      2: if (!m_ax && !m_sy) m_ay = 1'b1;
      default: if (!m_ay) m_sy = 1'b1;
    endcase
  endtask

  function automatic logic [7:0] code_of(int p);
    case (p)
      0: return C_IND;
      1: return C_AX;
      2: return C_AY;
      default: return C_SY;
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] ops [2];
    ops[0] = 8'h06;  // low bits 10: indirection applies
    ops[1] = 8'hA5;  // low bits 01: dual-form group
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9 / R10: reset state gives identity outputs
    m_ind = 0; m_ax = 0; m_ay = 0; m_sy = 0;
    check_selects("R9 reset");
    base_mode = 4'd2;
    #1;
    check(mode_out == 4'd2, "R9 R10 reset mode", mode_out, 2);
    irq_req = 1'b1;
    #1;
    check(irq_grant == 1'b1, "R9 reset irq", irq_grant, 1);

    for (int len = 0; len <= 3; len++) begin
      for (int idx = 0; idx < (1 << (2 * len)); idx++) begin
        m_ind = 0; m_ax = 0; m_ay = 0; m_sy = 0;
        // issue prefixes
        for (int k = 0; k < len; k++) begin
          int p;
          p = (idx >> (2 * k)) & 3;
          @(negedge clk);
          fetch_en = 1'b1;
          opcode = code_of(p);
          irq_req = 1'b1;
          #1;
          check(pfx_nop == 1'b1, "R7 prefix nop", pfx_nop, 1);
          check(irq_grant == 1'b0, "R8 irq during prefix", irq_grant, 0);
          model_prefix(p);
        end
        // idle cycle with stray insn_done before target
        @(negedge clk);
        fetch_en = 1'b0;
        opcode = 8'hEA;
        insn_done = (len > 0);
        irq_req = 1'b1;
        #1;
        check(irq_grant == (len == 0), "R8 irq held between prefix and target", irq_grant, len == 0);
        @(negedge clk);
        insn_done = 1'b0;
        #1;
        check(irq_inhibit == (len > 0), "R6 stray done ignored", irq_inhibit, len > 0);
        check_selects("R4 R5 R6 pending selects");
        // fetch the target instruction
        @(negedge clk);
        fetch_en = 1'b1;
        opcode = ops[0];
        base_mode = 4'd5;
        #1;
        check(pfx_nop == 1'b0, "R7 ordinary opcode", pfx_nop, 0);
        check(mode_out == exp_mode(5, m_ind, ops[0]), "R1 mode at fetch",
              mode_out, exp_mode(5, m_ind, ops[0]));
        @(negedge clk);
        fetch_en = 1'b0;
        #1;
        check(irq_grant == 1'b1, "R8 irq released after target fetch", irq_grant, 1);
        check_selects("R4 R5 active selects");
        for (int o = 0; o < 2; o++) begin
          for (int m = 0; m < 16; m++) begin
            opcode = ops[o];
            base_mode = 4'(m);
            #1;
            check(mode_out == exp_mode(m, m_ind, ops[o]), "R1 R2 R3 R10 mode remap",
                  mode_out, exp_mode(m, m_ind, ops[o]));
          end
        end
        // completion clears
        @(negedge clk);
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        m_ind = 0; m_ax = 0; m_ay = 0; m_sy = 0;
        opcode = ops[0];
        base_mode = 4'd3;
        #1;
        check(mode_out == 4'd3, "R6 mode after clear", mode_out, 3);
        check_selects("R6 selects after clear");
      end
    end

    // R9: reset in the middle of a pending prefix sequence
    @(negedge clk);
    fetch_en = 1'b1;
    opcode = C_AY;
    @(negedge clk);
    fetch_en = 1'b0;
    rst_n = 1'b0;
    #1;
    rst_n = 1'b1;
    m_ind = 0; m_ax = 0; m_ay = 0; m_sy = 0;
    #1;
    check_selects("R9 mid-sequence reset");
    check(irq_inhibit == 1'b0, "R9 inhibit cleared", irq_inhibit, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule